// File: doc/BRIEF.md
# Serial DAC Frame Receiver with Daisy-Chain

This block is the serial slave front end of a two-channel DAC controller. It watches three wires (an active-low frame sync, a serial clock and a serial data line) and assembles 16-bit command words, most significant bit first. It hands each finished word to a downstream register decoder as a 16-bit value with a strobe that lasts one clock. It does not decode commands.

All three wires are brought into the system clock domain through a synchronizer, and their edges are found from the sampled values. The system clock must therefore run at least four times faster than the serial clock.

A mode pin selects how a frame completes. In direct mode a word is committed on the 16th falling serial-clock edge of the frame, and a frame that ends early is dropped. In chain mode the block keeps shifting for as long as sync is low. It forwards the bits it receives on a serial output, delayed by 16 edges, so that several receivers can share one clock line and one sync line. The word is committed on the sync rising edge and holds the last 16 bits received. After each chain frame, one falling serial-clock edge while sync is high re-arms the receiver.

Top module: `serial_frame_rx`

## Requirements
- R1: While sync is low and the receiver is armed, each falling edge of the serial clock shifts one data bit in. The first bit of a frame becomes bit 15 of the word.
- R2: In direct mode (mode pin low), the 16th falling edge of a frame commits the word. The word holds the 16 bits of the frame.
- R3: In direct mode, clock edges after the 16th in the same frame are ignored. They produce no second strobe and do not alter the committed word.
- R4: In direct mode, a frame in which sync rises before the 16th edge produces no strobe, and `word_data` keeps its previous value.
- R5: If sync falls and rises with no serial-clock edge in between, no strobe is produced in either mode.
- R6: In chain mode (mode pin high), no word is committed while sync is low. The sync rising edge commits the last 16 bits received.
- R7: In chain mode, a frame that ends with fewer than 16 bits produces no strobe.
- R8: In chain mode with sync low, the serial output carries the bit received 16 falling edges earlier in the same frame. Before 16 bits have arrived in the frame, it carries 0.
- R9: `sdo_oe` is 1 only while chain mode is selected and sync is low. While `sdo_oe` is 0, `sdo_out` is 0.
- R10: In chain mode, after sync rises the receiver ignores every frame until it has seen one falling serial-clock edge with sync high.
- R11: `word_valid` lasts exactly one clock for each committed word, and `word_data` changes only in a strobe cycle.
- R12: After reset, `word_valid`, `word_data`, `sdo_oe` and `sdo_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| daisy_en | input | 1 | Mode: 0 direct, 1 chain (held steady between frames) |
| sclk_in | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n_in | input | 1 | Active-low frame sync |
| sdi_in | input | 1 | Serial data in, MSB first |
| sdo_out | output | 1 | Chained serial data out (bit from 16 edges earlier) |
| sdo_oe | output | 1 | Output enable for `sdo_out` (high-impedance when 0) |
| word_valid | output | 1 | One-clock strobe marking a committed word |
| word_data | output | 16 | Last committed command word |

## Verification
The assertions assume that the serial wires change slowly compared with the system clock. Each serial-clock phase lasts several system cycles, data is stable across every falling edge, and sync does not change in the same system cycle as a serial-clock edge. They also assume that the mode pin changes only while sync is high. The bench respects all of this by construction. It holds each serial-clock phase for four system cycles, sets data half a period before each falling edge, and waits several cycles on each side of every sync transition. It changes the mode only between frames.

// File: rtl/sdfr_pkg.sv
`timescale 1ns/1ps
package sdfr_pkg;

    localparam int unsigned WORD_W_DEF      = 16;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // raw serial pins bundled together
    typedef struct packed {
        logic sclk;
        logic sync_n;
        logic sdi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b1, sync_n: 1'b1, sdi: 1'b0};

    // events derived from the synchronized pins
    typedef struct packed {
        logic sclk_fall;
        logic sync_fall;
        logic sync_rise;
        logic frame_low;
        logic sdi;
    } evt_t;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_CHAIN  = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        CMT_NONE      = 2'd0,
        CMT_LAST_BIT  = 2'd1,
        CMT_SYNC_RISE = 2'd2
    } commit_e;

    function automatic int unsigned cnt_width(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/sdfr_sync.sv
`timescale 1ns/1ps
module sdfr_sync
    import sdfr_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t raw,
    output pins_t synced
);
    localparam int unsigned PW = $bits(pins_t);

    logic [PW-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= PINS_IDLE;
                    else     stage_q[g] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= PINS_IDLE;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign synced = pins_t'(stage_q[STAGES-1]);

endmodule

// File: rtl/sdfr_edge.sv
`timescale 1ns/1ps
module sdfr_edge
    import sdfr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t cur,
    output evt_t  ev
);
    pins_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PINS_IDLE;
        else     prev_q <= cur;
    end

    always_comb begin
        ev.sclk_fall = prev_q.sclk & ~cur.sclk;
        ev.sync_fall = prev_q.sync_n & ~cur.sync_n;
        ev.sync_rise = ~prev_q.sync_n & cur.sync_n;
        ev.frame_low = ~cur.sync_n;
        ev.sdi       = cur.sdi;
    end

endmodule

// File: rtl/sdfr_frame_ctl.sv
`timescale 1ns/1ps
module sdfr_frame_ctl
    import sdfr_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    localparam int unsigned CW    = cnt_width(WORD_W)
) (
    input  logic    clk,
    input  logic    rst,
    input  evt_t    ev,
    input  mode_e   mode,
    output logic    shift_en,
    output logic    clear_sr,
    output commit_e commit
);
    localparam logic [CW-1:0] FULL = CW'(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_base;
    logic          armed_q;

    always_comb begin
        cnt_base = ev.sync_fall ? '0 : cnt_q;
        clear_sr = ev.sync_fall;
        shift_en = ev.sclk_fall & ev.frame_low & armed_q &
                   ((mode == MODE_CHAIN) | (cnt_base != FULL));
        commit   = CMT_NONE;
        if (mode == MODE_DIRECT && shift_en && cnt_base == LAST)
            commit = CMT_LAST_BIT;
        else if (mode == MODE_CHAIN && ev.sync_rise && cnt_q == FULL)
            commit = CMT_SYNC_RISE;
    end

    // bit counter, saturating at the word length
    always_ff @(posedge clk) begin
        if (rst)                            cnt_q <= '0;
        else if (!ev.frame_low)             cnt_q <= '0;
        else if (shift_en && cnt_base != FULL) cnt_q <= cnt_base + 1'b1;
        else                                cnt_q <= cnt_base;
    end

    // chain mode needs one clock edge with sync high before the next frame
    always_ff @(posedge clk) begin
        if (rst)                                   armed_q <= 1'b1;
        else if (mode == MODE_DIRECT)              armed_q <= 1'b1;
        else if (ev.sync_rise)                     armed_q <= 1'b0;
        else if (ev.sclk_fall && !ev.frame_low)    armed_q <= 1'b1;
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    // R10
    chain_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHAIN && ev.sync_rise) |=> !armed_q);

endmodule

// File: rtl/sdfr_shift.sv
`timescale 1ns/1ps
module sdfr_shift
    import sdfr_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              sdi,
    output logic [WORD_W-1:0] sr,
    output logic [WORD_W-1:0] next_word,
    output logic              msb
);
    logic [WORD_W-1:0] base;

    always_comb begin
        base      = clear ? '0 : sr;
        next_word = {base[WORD_W-2:0], sdi};
        msb       = sr[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (shift_en) sr <= next_word;
        else if (clear)    sr <= '0;
    end

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr[0] == $past(sdi));

endmodule

// File: rtl/serial_frame_rx.sv
`timescale 1ns/1ps
module serial_frame_rx
    import sdfr_pkg::*;
#(
    parameter int unsigned WORD_W      = WORD_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              daisy_en,
    input  logic              sclk_in,
    input  logic              sync_n_in,
    input  logic              sdi_in,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);
    pins_t             raw_pins;
    pins_t             syn_pins;
    evt_t              ev;
    mode_e             mode;
    logic              shift_en;
    logic              clear_sr;
    commit_e           commit;
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] next_word;
    logic              msb;

    assign raw_pins = '{sclk: sclk_in, sync_n: sync_n_in, sdi: sdi_in};
    assign mode     = daisy_en ? MODE_CHAIN : MODE_DIRECT;

    sdfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_pins),
        .synced (syn_pins)
    );

    sdfr_edge u_edge (
        .clk (clk),
        .rst (rst),
        .cur (syn_pins),
        .ev  (ev)
    );

    sdfr_frame_ctl #(.WORD_W(WORD_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .mode     (mode),
        .shift_en (shift_en),
        .clear_sr (clear_sr),
        .commit   (commit)
    );

    sdfr_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear_sr),
        .shift_en  (shift_en),
        .sdi       (ev.sdi),
        .sr        (sr),
        .next_word (next_word),
        .msb       (msb)
    );

    assign sdo_oe  = (mode == MODE_CHAIN) & ev.frame_low;
    assign sdo_out = sdo_oe & msb;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            case (commit)
                CMT_LAST_BIT: begin
                    word_valid <= 1'b1;
                    word_data  <= next_word;
                end
                CMT_SYNC_RISE: begin
                    word_valid <= 1'b1;
                    word_data  <= sr;
                end
                default: ;
            endcase
        end
    end

    // R11
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_data));

    // R9
    oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> (daisy_en && syn_pins.sync_n == 1'b0));

    // R6
    chain_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && daisy_en) |-> !ev.frame_low);

endmodule

// File: tb/serial_frame_rx_tb.sv
`timescale 1ns/1ps
module serial_frame_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        daisy_en = 1'b0;
    logic        sclk_in = 1'b1;
    logic        sync_n_in = 1'b1;
    logic        sdi_in = 1'b0;
    logic        sdo_out;
    logic        sdo_oe;
    logic        word_valid;
    logic [15:0] word_data;

    int          tests = 0;
    int          fails = 0;
    int          vcnt  = 0;
    logic [15:0] vdata = '0;
    bit          done  = 1'b0;
    logic        stream [64];
    logic        cap    [64];

    always #4 clk = ~clk;

    serial_frame_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .daisy_en   (daisy_en),
        .sclk_in    (sclk_in),
        .sync_n_in  (sync_n_in),
        .sdi_in     (sdi_in),
        .sdo_out    (sdo_out),
        .sdo_oe     (sdo_oe),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    always @(posedge clk) begin
        if (!rst && word_valid) begin
            vcnt  <= vcnt + 1;
            vdata <= word_data;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        sync_n_in = 1'b0;
        wait_n(6);
    endtask

    task automatic frame_end();
        wait_n(4);
        sync_n_in = 1'b1;
        wait_n(8);
    endtask

    task automatic run_bits(input int n);
        for (int k = 0; k < n; k++) begin
            sdi_in = stream[k];
            wait_n(4);
            cap[k]  = sdo_out;
            sclk_in = 1'b0;
            wait_n(4);
            sclk_in = 1'b1;
        end
    endtask

    task automatic idle_pulse();
        sclk_in = 1'b0;
        wait_n(4);
        sclk_in = 1'b1;
        wait_n(4);
    endtask

    task automatic load_word(input logic [15:0] w, input int base);
        for (int k = 0; k < 16; k++) stream[base + k] = w[15 - k];
    endtask

    initial begin
        int          v0;
        logic [15:0] w;
        logic [15:0] w2;
        logic [15:0] prev;
        bit          ok;

        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        // R12 reset state
        chk(word_valid == 1'b0, "R12 valid", word_valid, 0);
        chk(word_data == 16'h0, "R12 data", word_data, 0);
        chk(sdo_oe == 1'b0, "R12 oe", sdo_oe, 0);
        chk(sdo_out == 1'b0, "R12 sdo", sdo_out, 0);

        // R1 R2 R9: direct mode sweep over walking ones and arithmetic patterns
        for (int i = 0; i < 40; i++) begin
            w = (i < 16) ? (16'h1 << i) : 16'((i * 16'h1357) ^ (i << 9));
            load_word(w, 0);
            v0 = vcnt;
            frame_begin();
            chk(sdo_oe == 1'b0, "R9 oe direct", sdo_oe, 0);
            run_bits(16);
            wait_n(6);
            chk(vcnt == v0 + 1, "R2 one strobe", vcnt, v0 + 1);
            chk(vdata == w, "R1 R2 word", vdata, w);
            frame_end();
        end

        // R3: extra bits after 16 ignored
        w = 16'hC3A5;
        load_word(w, 0);
        load_word(16'hFFFF, 16);
        v0 = vcnt;
        frame_begin();
        run_bits(21);
        frame_end();
        chk(vcnt == v0 + 1, "R3 single strobe", vcnt, v0 + 1);
        chk(word_data == w, "R3 word kept", word_data, w);

        // R4: aborted frames of every short length
        prev = word_data;
        for (int n = 1; n < 16; n++) begin
            load_word(16'h5A5A ^ 16'(n), 0);
            v0 = vcnt;
            frame_begin();
            run_bits(n);
            frame_end();
            chk(vcnt == v0, "R4 no strobe", vcnt, v0);
            chk(word_data == prev, "R4 data held", word_data, prev);
        end

        // R5: sync toggle with no clock, direct mode
        v0 = vcnt;
        frame_begin();
        frame_end();
        chk(vcnt == v0, "R5 direct", vcnt, v0);

        // chain mode
        daisy_en = 1'b1;
        wait_n(4);

        // R6 R8 R9: 32-bit chain frame
        w  = 16'h1234;
        w2 = 16'hBEEF;
        load_word(w, 0);
        load_word(w2, 16);
        v0 = vcnt;
        frame_begin();
        chk(sdo_oe == 1'b1, "R9 oe chain", sdo_oe, 1);
        run_bits(32);
        ok = 1'b1;
        for (int k = 0; k < 32; k++) begin
            if (cap[k] !== ((k >= 16) ? stream[k - 16] : 1'b0)) ok = 1'b0;
        end
        chk(ok, "R8 delayed output", {31'b0, ok}, 1);
        wait_n(6);
        chk(vcnt == v0, "R6 no early commit", vcnt, v0);
        frame_end();
        chk(vcnt == v0 + 1, "R6 commit on rise", vcnt, v0 + 1);
        chk(vdata == w2, "R6 last 16 bits", vdata, w2);
        chk(sdo_oe == 1'b0 && sdo_out == 1'b0, "R9 oe off", {sdo_oe, sdo_out}, 0);
        idle_pulse();

        // R6 sweep: frames of 16..24 bits commit the trailing 16
        for (int n = 16; n <= 24; n++) begin
            for (int k = 0; k < n; k++) stream[k] = 1'((k * 7 + n) % 3 == 0);
            w = '0;
            for (int k = 0; k < 16; k++) w[15 - k] = stream[n - 16 + k];
            v0 = vcnt;
            frame_begin();
            run_bits(n);
            frame_end();
            chk(vcnt == v0 + 1 && vdata == w, "R6 trailing word", vdata, w);
            idle_pulse();
        end

        // R7: short chain frame
        load_word(16'h0F0F, 0);
        v0 = vcnt;
        frame_begin();
        run_bits(10);
        frame_end();
        chk(vcnt == v0, "R7 short chain", vcnt, v0);
        idle_pulse();

        // R5: chain sync toggle without clock
        v0 = vcnt;
        frame_begin();
        frame_end();
        chk(vcnt == v0, "R5 chain", vcnt, v0);
        idle_pulse();

        // R10: frame right after a commit, without a re-arm edge, is ignored
        load_word(16'hAAAA, 0);
        load_word(16'h5555, 16);
        frame_begin();
        run_bits(32);
        frame_end();
        v0 = vcnt;
        prev = word_data;
        load_word(16'h7E81, 0);
        frame_begin();
        run_bits(16);
        frame_end();
        chk(vcnt == v0, "R10 ignored frame", vcnt, v0);
        chk(word_data == prev, "R10 data held", word_data, prev);
        idle_pulse();
        w = 16'h7E81;
        load_word(w, 0);
        frame_begin();
        run_bits(16);
        frame_end();
        chk(vcnt == v0 + 1 && vdata == w, "R10 rearmed", vdata, w);

        // R11: strobe width observed at the port
        daisy_en = 1'b0;
        wait_n(4);
        load_word(16'h9669, 0);
        frame_begin();
        run_bits(15);
        sdi_in = stream[15];
        wait_n(4);
        sclk_in = 1'b0;
        begin
            int hi = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (word_valid) hi++;
            end
            chk(hi == 1, "R11 pulse width", hi, 1);
        end
        sclk_in = 1'b1;
        frame_end();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule